// File: doc/BRIEF.md
# Open-Row DRAM Command Sequencer

This block turns single-beat memory requests into commands for a single-data-rate synchronous DRAM with four banks. A request carries a write flag, a 23-bit address and write data. The block cuts the address into a row, a bank and a column. For each bank it keeps a record of whether a row is open and which row that is.

A request to the row already open in its bank is served with one read or write command. A request to a closed bank first needs an activate command. A request that meets a different open row needs a precharge, then an activate, then the column command. Minimum cycle gaps between these commands are parameters.

A free-running interval timer asks for a refresh at a fixed period. While that request is pending, no new work is accepted. The block closes every open bank, issues the refresh, waits out the refresh time and then resumes. Read data arrives from the memory a fixed CAS latency after the read command, and the block passes it to the requester one cycle later. The block handles one request at a time and drives at most one command per cycle.

Top module: `dram_open_row_seq`

## Requirements
- R1: The request address is split as row = addr[22:11], bank = addr[10:9] and column = addr[8:0]. An activate carries that row and bank. A read or write carries that bank and column.
- R2: A bank receives an activate only while it has no open row. On a row miss, the command order for that request is precharge of that bank (code 4), then activate (code 1), then the column command.
- R3: A request whose row is already open in its bank is served by a read (code 2) or write (code 3) alone, with no precharge or activate in between.
- R4: Same-bank command gaps of at least T_RCD cycles from activate to column command, T_RP cycles from precharge to activate, and T_RAS cycles from activate to precharge are kept. A gap is the difference of the cycles in which the commands appear.
- R5: A refresh (code 6) appears once per REF_INTERVAL cycles, within a bounded delay, and only while every bank is closed and T_RP cycles after the last precharge. Open banks are closed first by one precharge-all (code 5). No command appears within T_RFC cycles after a refresh.
- R6: rsp_valid rises CAS_LAT+1 cycles after a read command appears. rsp_rdata then holds the value on dram_rdata CAS_LAT cycles after that read.
- R7: Once a request is accepted, req_ready stays low until its column command appears on the bus. No request is accepted during a refresh sequence.
- R8: A write command carries the request's data on cmd_wdata in the same cycle.
- R9: After reset the command bus shows no-operation (code 0), req_ready is high and rsp_valid is low.
- R10: After a refresh every bank is closed, so the next request issues activate and then its column command, with no precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Request address (row, bank, column) |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 16 | Read data |
| cmd_op | output | 3 | Command code: 0 nop, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge-all, 6 refresh |
| cmd_bank | output | 2 | Command bank |
| cmd_row | output | 12 | Row for activate |
| cmd_col | output | 9 | Column for read or write |
| cmd_wdata | output | 16 | Data sent with a write |
| dram_rdata | input | 16 | Data returned by the memory |

## Verification
The assertions assume that req_valid, req_addr, req_we and req_wdata do not change while a request waits for req_ready. The stimulus drives these inputs shortly after a clock edge and holds them until the request is taken. The assertions also assume that dram_rdata is stable at the sampling edge CAS_LAT cycles after a read. The bench's memory model drives it half a cycle before that edge. Addresses are drawn from a few rows in every bank, so hits, closed-bank accesses and row conflicts are frequent. Idle gaps let refreshes fall both with banks open and with all banks closed.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_PREA = 3'd5,
        CMD_REF  = 3'd6
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SERVE    = 3'd1,
        ST_REF_PRE  = 3'd2,
        ST_REF_RP   = 3'd3,
        ST_REF_WAIT = 3'd4
    } seq_st_e;

endpackage

// File: rtl/dseq_bank_track.sv
module dseq_bank_track
    import dseq_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RAS  = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  cmd_e                           issue_op,
    input  logic [BANK_W-1:0]              issue_bank,
    input  logic [ROW_W-1:0]               issue_row,
    output logic [NBANK-1:0]               open_o,
    output logic [NBANK-1:0][ROW_W-1:0]    row_o,
    output logic [NBANK-1:0]               rcd_ok_o,
    output logic [NBANK-1:0]               rp_ok_o,
    output logic [NBANK-1:0]               ras_ok_o
);

    localparam int TMAX0 = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int TMAX  = (TMAX0 > T_RAS) ? TMAX0 : T_RAS;
    localparam int TW    = $clog2(TMAX + 1);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [TW-1:0]    rcd;
        logic [TW-1:0]    rp;
        logic [TW-1:0]    ras;
    } bank_s;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        bank_s b_d, b_q;
        logic  sel;

        assign sel = (issue_bank == BANK_W'(g));

        always_comb begin
            b_d = b_q;
            if (b_q.rcd != '0) b_d.rcd = b_q.rcd - 1'b1;
            if (b_q.rp  != '0) b_d.rp  = b_q.rp  - 1'b1;
            if (b_q.ras != '0) b_d.ras = b_q.ras - 1'b1;
            if (issue_op == CMD_ACT && sel) begin
                b_d.open = 1'b1;
                b_d.row  = issue_row;
                b_d.rcd  = TW'(T_RCD - 1);
                b_d.ras  = TW'(T_RAS - 1);
            end
            if ((issue_op == CMD_PRE && sel) || issue_op == CMD_PREA) begin
                b_d.open = 1'b0;
                b_d.rp   = TW'(T_RP - 1);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) b_q <= '0;
            else        b_q <= b_d;
        end

        assign open_o[g]   = b_q.open;
        assign row_o[g]    = b_q.row;
        assign rcd_ok_o[g] = (b_q.rcd == '0);
        assign rp_ok_o[g]  = (b_q.rp == '0);
        assign ras_ok_o[g] = (b_q.ras == '0);

        AST_ACT_ONLY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n) (issue_op == CMD_ACT && sel) |-> !b_q.open) else $error("activate to open bank"); // R2
        AST_COL_AFTER_RCD: assert property (@(posedge clk) disable iff (!rst_n) ((issue_op == CMD_RD || issue_op == CMD_WR) && sel) |-> (b_q.open && b_q.rcd == '0)) else $error("column too early"); // R4
        AST_PRE_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n) (issue_op == CMD_PRE && sel) |-> (b_q.open && b_q.ras == '0)) else $error("precharge too early"); // R4
        AST_ACT_AFTER_RP: assert property (@(posedge clk) disable iff (!rst_n) (issue_op == CMD_ACT && sel) |-> (b_q.rp == '0)) else $error("activate too early"); // R4
    end

endmodule

// File: rtl/dseq_refresh_timer.sv
module dseq_refresh_timer #(
    parameter int INTERVAL = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_issue,
    output logic pending_o
);

    localparam int CW = $clog2(INTERVAL);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } tmr_s;

    tmr_s t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (ref_issue) t_d.pend = 1'b0;
        if (t_q.cnt == CW'(INTERVAL - 1)) begin
            t_d.cnt  = '0;
            t_d.pend = 1'b1;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign pending_o = t_q.pend;

    AST_REF_ONLY_WHEN_DUE: assert property (@(posedge clk) disable iff (!rst_n) ref_issue |-> t_q.pend) else $error("refresh without request"); // R5

endmodule

// File: rtl/dseq_rd_return.sv
module dseq_rd_return #(
    parameter int CAS_LAT = 3,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_seen,
    input  logic [DATA_W-1:0] dram_rdata,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_rdata_o
);

    typedef struct packed {
        logic [CAS_LAT-1:0] sr;
        logic               valid;
        logic [DATA_W-1:0]  data;
    } ret_s;

    ret_s r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.sr[0] = rd_seen;
        for (int i = 1; i < CAS_LAT; i++) r_d.sr[i] = r_q.sr[i-1];
        r_d.valid = r_q.sr[CAS_LAT-1];
        if (r_q.sr[CAS_LAT-1]) r_d.data = dram_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_valid_o = r_q.valid;
    assign rsp_rdata_o = r_q.data;

endmodule

// File: rtl/dram_open_row_seq.sv
module dram_open_row_seq
    import dseq_pkg::*;
#(
    parameter int ROW_W        = 12,
    parameter int BANK_W       = 2,
    parameter int COL_W        = 9,
    parameter int DATA_W       = 16,
    parameter int T_RCD        = 3,
    parameter int T_RP         = 3,
    parameter int T_RAS        = 6,
    parameter int T_RFC        = 10,
    parameter int REF_INTERVAL = 300,
    parameter int CAS_LAT      = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_we,
    input  logic [ROW_W+BANK_W+COL_W-1:0] req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic                          rsp_valid,
    output logic [DATA_W-1:0]             rsp_rdata,
    output logic [2:0]                    cmd_op,
    output logic [BANK_W-1:0]             cmd_bank,
    output logic [ROW_W-1:0]              cmd_row,
    output logic [COL_W-1:0]              cmd_col,
    output logic [DATA_W-1:0]             cmd_wdata,
    input  logic [DATA_W-1:0]             dram_rdata
);

    localparam int NBANK = 1 << BANK_W;
    localparam int FW    = $clog2(T_RFC + 1);

    typedef struct packed {
        seq_st_e           st;
        logic              we;
        logic [ROW_W-1:0]  row;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
        logic [FW-1:0]     rfc;
        cmd_e              op;
        logic [BANK_W-1:0] obank;
        logic [ROW_W-1:0]  orow;
        logic [COL_W-1:0]  ocol;
        logic [DATA_W-1:0] owdata;
    } seq_s;

    seq_s s_d, s_q;

    logic [NBANK-1:0]            bank_open;
    logic [NBANK-1:0][ROW_W-1:0] open_row;
    logic [NBANK-1:0]            rcd_ok, rp_ok, ras_ok;
    logic                        ref_pending;

    assign req_ready = (s_q.st == ST_IDLE) && !ref_pending;

    always_comb begin
        s_d        = s_q;
        s_d.op     = CMD_NOP;
        s_d.obank  = '0;
        s_d.orow   = '0;
        s_d.ocol   = '0;
        s_d.owdata = '0;
        case (s_q.st)
            ST_IDLE: begin
                if (ref_pending) begin
                    s_d.st = ST_REF_PRE;
                end else if (req_valid) begin
                    s_d.st    = ST_SERVE;
                    s_d.we    = req_we;
                    s_d.col   = req_addr[COL_W-1:0];
                    s_d.bank  = req_addr[COL_W +: BANK_W];
                    s_d.row   = req_addr[COL_W+BANK_W +: ROW_W];
                    s_d.wdata = req_wdata;
                end
            end
            ST_SERVE: begin
                if (bank_open[s_q.bank] && open_row[s_q.bank] == s_q.row) begin
                    if (rcd_ok[s_q.bank]) begin
                        s_d.op     = s_q.we ? CMD_WR : CMD_RD;
                        s_d.obank  = s_q.bank;
                        s_d.ocol   = s_q.col;
                        s_d.owdata = s_q.we ? s_q.wdata : '0;
                        s_d.st     = ST_IDLE;
                    end
                end else if (bank_open[s_q.bank]) begin
                    if (ras_ok[s_q.bank]) begin
                        s_d.op    = CMD_PRE;
                        s_d.obank = s_q.bank;
                    end
                end else if (rp_ok[s_q.bank]) begin
                    s_d.op    = CMD_ACT;
                    s_d.obank = s_q.bank;
                    s_d.orow  = s_q.row;
                end
            end
            ST_REF_PRE: begin
                if (|bank_open) begin
                    if (&(ras_ok | ~bank_open)) begin
                        s_d.op = CMD_PREA;
                        s_d.st = ST_REF_RP;
                    end
                end else begin
                    s_d.st = ST_REF_RP;
                end
            end
            ST_REF_RP: begin
                if (&rp_ok) begin
                    s_d.op  = CMD_REF;
                    s_d.rfc = FW'(T_RFC - 1);
                    s_d.st  = ST_REF_WAIT;
                end
            end
            ST_REF_WAIT: begin
                if (s_q.rfc == '0) s_d.st  = ST_IDLE;
                else               s_d.rfc = s_q.rfc - 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    dseq_bank_track #(
        .NBANK (NBANK),
        .BANK_W(BANK_W),
        .ROW_W (ROW_W),
        .T_RCD (T_RCD),
        .T_RP  (T_RP),
        .T_RAS (T_RAS)
    ) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_op  (s_d.op),
        .issue_bank(s_d.obank),
        .issue_row (s_d.orow),
        .open_o    (bank_open),
        .row_o     (open_row),
        .rcd_ok_o  (rcd_ok),
        .rp_ok_o   (rp_ok),
        .ras_ok_o  (ras_ok)
    );

    dseq_refresh_timer #(
        .INTERVAL(REF_INTERVAL)
    ) u_refresh (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_issue(s_d.op == CMD_REF),
        .pending_o(ref_pending)
    );

    dseq_rd_return #(
        .CAS_LAT(CAS_LAT),
        .DATA_W (DATA_W)
    ) u_rdret (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_seen    (s_q.op == CMD_RD),
        .dram_rdata (dram_rdata),
        .rsp_valid_o(rsp_valid),
        .rsp_rdata_o(rsp_rdata)
    );

    assign cmd_op    = s_q.op;
    assign cmd_bank  = s_q.obank;
    assign cmd_row   = s_q.orow;
    assign cmd_col   = s_q.ocol;
    assign cmd_wdata = s_q.owdata;

    AST_SINGLE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !req_ready) else $error("second request taken"); // R7
    AST_REF_BANKS_CLOSED: assert property (@(posedge clk) disable iff (!rst_n) (s_d.op == CMD_REF) |-> (bank_open == '0)) else $error("refresh with open bank"); // R5
    AST_REF_QUIET_AFTER: assert property (@(posedge clk) disable iff (!rst_n) (s_q.op == CMD_REF) |=> (s_q.op == CMD_NOP)) else $error("command right after refresh"); // R5

endmodule

// File: tb/tb_dram_open_row_seq.sv
module tb_dram_open_row_seq;

    localparam int T_RCD = 3, T_RP = 3, T_RAS = 6, T_RFC = 10;
    localparam int REF_INTERVAL = 300, CAS_LAT = 3, SLACK = 40;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [22:0] req_addr = '0;
    logic [15:0] req_wdata = '0, dram_rdata = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata, cmd_wdata;
    logic [2:0]  cmd_op;
    logic [1:0]  cmd_bank;
    logic [11:0] cmd_row;
    logic [8:0]  cmd_col;

    always #2 clk = ~clk;

    dram_open_row_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .cmd_wdata(cmd_wdata), .dram_rdata(dram_rdata)
    );

    typedef struct {
        bit          we;
        int          addr;
        logic [15:0] wd;
        int          kind;
        bit          pre_seen;
        bit          act_seen;
        logic [15:0] exp_rd;
    } req_t;
    typedef struct { int c; logic [15:0] d; } tim_t;

    int total = 0, bad = 0, cyc = 0, nref = 0;
    int last_ref = -1000, ref_base = 0;
    bit open_b[4];
    int orow[4], last_act[4], last_pre[4];
    logic [15:0] dmem[int];
    logic [15:0] gold[int];
    req_t rq[$];
    tim_t dq[$];
    tim_t eq[$];

    function automatic logic [15:0] dflt(int k);
        return 16'(k) ^ 16'h5A3C;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    initial begin
        for (int b = 0; b < 4; b++) begin
            open_b[b] = 0; orow[b] = 0; last_act[b] = -1000; last_pre[b] = -1000;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            int b, hb, hrow, hcol, key;
            cyc++;
            if (dq.size() > 0 && dq[0].c == cyc) begin
                dram_rdata = dq[0].d;
                void'(dq.pop_front());
            end
            if (cyc == 1) begin
                chk(cmd_op == 3'd0, "R9 command after reset", cmd_op, 0);
                chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);
                chk(rsp_valid == 1'b0, "R9 rsp_valid after reset", rsp_valid, 0);
            end
            if (eq.size() > 0 && eq[0].c < cyc) begin
                chk(0, "R6 missing read response", 0, eq[0].c);
                void'(eq.pop_front());
            end
            if (rsp_valid) begin
                if (eq.size() == 0) chk(0, "R6 unexpected response", 1, 0);
                else begin
                    chk(eq[0].c == cyc, "R6 response cycle", cyc, eq[0].c);
                    chk(rsp_rdata == eq[0].d, "R6 response data", rsp_rdata, eq[0].d);
                    void'(eq.pop_front());
                end
            end
            b = int'(cmd_bank);
            hb = 0; hrow = 0; hcol = 0;
            if (rq.size() > 0) begin
                hb = (rq[0].addr >> 9) & 3; hrow = rq[0].addr >> 11; hcol = rq[0].addr & 511;
            end
            if (cmd_op != 3'd0 && cmd_op != 3'd6)
                chk(cyc - last_ref >= T_RFC, "R5 command inside refresh time", cyc - last_ref, T_RFC);
            case (cmd_op)
                3'd0: ;
                3'd1: begin
                    chk(rq.size() > 0, "R2 activate without request", 0, 1);
                    chk(!open_b[b], "R2 activate to open bank", open_b[b], 0);
                    chk(cyc - last_pre[b] >= T_RP, "R4 precharge-to-activate gap", cyc - last_pre[b], T_RP);
                    if (rq.size() > 0) begin
                        chk(b == hb, "R1 activate bank", b, hb);
                        chk(int'(cmd_row) == hrow, "R1 activate row", cmd_row, hrow);
                        chk(rq[0].kind != 0, "R3 activate on a row hit", rq[0].kind, 0);
                        if (rq[0].kind == 2) chk(rq[0].pre_seen, "R2 activate before precharge on miss", 0, 1);
                        rq[0].act_seen = 1;
                    end
                    open_b[b] = 1; orow[b] = int'(cmd_row); last_act[b] = cyc;
                end
                3'd4: begin
                    chk(open_b[b], "R2 precharge of closed bank", open_b[b], 1);
                    chk(cyc - last_act[b] >= T_RAS, "R4 activate-to-precharge gap", cyc - last_act[b], T_RAS);
                    if (rq.size() > 0) begin
                        chk(rq[0].kind == 2, "R10 precharge when not a row miss", rq[0].kind, 2);
                        chk(!rq[0].pre_seen && !rq[0].act_seen && b == hb, "R2 precharge order", b, hb);
                        rq[0].pre_seen = 1;
                    end else chk(0, "R2 precharge without request", 0, 1);
                    open_b[b] = 0; last_pre[b] = cyc;
                end
                3'd2, 3'd3: begin
                    if (rq.size() == 0) chk(0, "R1 column command without request", 0, 1);
                    else begin
                        chk(open_b[b] && orow[b] == hrow, "R1 column row open", orow[b], hrow);
                        chk(b == hb, "R1 column bank", b, hb);
                        chk(int'(cmd_col) == hcol, "R1 column address", cmd_col, hcol);
                        chk((cmd_op == 3'd3) == rq[0].we, "R1 read/write kind", cmd_op, rq[0].we ? 3 : 2);
                        chk(cyc - last_act[b] >= T_RCD, "R4 activate-to-column gap", cyc - last_act[b], T_RCD);
                        if (rq[0].kind == 0)
                            chk(!rq[0].act_seen && !rq[0].pre_seen, "R3 hit served by column command alone", rq[0].act_seen, 0);
                        else if (rq[0].kind == 1)
                            chk(rq[0].act_seen && !rq[0].pre_seen, "R10 closed bank needs activate only", rq[0].pre_seen, 0);
                        else
                            chk(rq[0].act_seen && rq[0].pre_seen, "R2 miss needs precharge and activate", rq[0].act_seen, 1);
                        key = (orow[b] << 11) | (b << 9) | int'(cmd_col);
                        if (cmd_op == 3'd3) begin
                            chk(cmd_wdata == rq[0].wd, "R8 write data with command", cmd_wdata, rq[0].wd);
                            dmem[key] = cmd_wdata;
                        end else begin
                            tim_t t;
                            t.c = cyc + CAS_LAT;
                            t.d = dmem.exists(key) ? dmem[key] : dflt(key);
                            dq.push_back(t);
                            t.c = cyc + CAS_LAT + 1;
                            t.d = rq[0].exp_rd;
                            eq.push_back(t);
                        end
                        void'(rq.pop_front());
                    end
                end
                3'd5: begin
                    chk(rq.size() == 0, "R5 precharge-all during request", rq.size(), 0);
                    for (int i = 0; i < 4; i++) begin
                        if (open_b[i]) chk(cyc - last_act[i] >= T_RAS, "R4 activate-to-precharge-all gap", cyc - last_act[i], T_RAS);
                        open_b[i] = 0; last_pre[i] = cyc;
                    end
                end
                3'd6: begin
                    chk(rq.size() == 0, "R7 refresh while request outstanding", rq.size(), 0);
                    for (int i = 0; i < 4; i++) begin
                        chk(!open_b[i], "R5 refresh with open bank", i, -1);
                        chk(cyc - last_pre[i] >= T_RP, "R5 refresh before tRP", cyc - last_pre[i], T_RP);
                    end
                    chk(cyc - ref_base <= REF_INTERVAL + SLACK, "R5 refresh too late", cyc - ref_base, REF_INTERVAL);
                    chk(cyc - ref_base >= REF_INTERVAL - SLACK, "R5 refresh too early", cyc - ref_base, REF_INTERVAL);
                    last_ref = cyc; ref_base = cyc; nref++;
                end
                default: chk(0, "R1 illegal command code", cmd_op, 0);
            endcase
            if (rq.size() > 0) chk(!req_ready, "R7 ready while request outstanding", req_ready, 0);
            if (req_valid && req_ready) begin
                req_t r;
                int rb, rr;
                r.we = req_we; r.addr = int'(req_addr); r.wd = req_wdata;
                r.pre_seen = 0; r.act_seen = 0; r.exp_rd = '0;
                rb = (r.addr >> 9) & 3; rr = r.addr >> 11;
                r.kind = !open_b[rb] ? 1 : (orow[rb] == rr ? 0 : 2);
                if (r.we) gold[r.addr] = r.wd;
                else r.exp_rd = gold.exists(r.addr) ? gold[r.addr] : dflt(r.addr);
                rq.push_back(r);
            end
        end
    end

    task automatic send(input bit we, input int row, input int bank, input int col, input logic [15:0] wd);
        req_valid = 1'b1; req_we = we; req_wdata = wd;
        req_addr = 23'((row << 11) | (bank << 9) | col);
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(2);
        // closed bank then row hits, writes then reads back
        for (int c = 0; c < 4; c++) send(1, 5, 0, c, 16'h1000 + 16'(c));
        for (int c = 0; c < 4; c++) send(0, 5, 0, c, 0);
        // row conflicts in one bank
        send(1, 9, 0, 3, 16'hBEEF);
        send(0, 5, 0, 2, 0);
        send(0, 9, 0, 3, 0);
        // bank interleave
        for (int b = 0; b < 4; b++) send(1, 100 + b, b, 7, 16'h2200 + 16'(b));
        for (int b = 3; b >= 0; b--) send(0, 100 + b, b, 7, 0);
        idle(350);
        // mixed traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(lfsr[9], int'(lfsr[1:0]), int'(lfsr[3:2]), int'(lfsr[6:4]), lfsr ^ 16'h0F0F);
            if (lfsr[11:10] == 2'b11) idle(int'(lfsr[15:12]));
        end
        idle(400);
        chk(rq.size() == 0, "R7 requests left unserved", rq.size(), 0);
        chk(eq.size() == 0, "R6 reads without response", eq.size(), 0);
        chk(nref >= cyc / REF_INTERVAL - 1, "R5 refresh count", nref, cyc / REF_INTERVAL);
        chk(cyc - ref_base <= REF_INTERVAL + SLACK, "R5 refresh overdue at end", cyc - ref_base, REF_INTERVAL);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule